// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands by repeated conditional addition, spending one clock cycle per bit of the multiplier operand. When a start request is accepted, it latches both operands, clears its accumulator and then iterates. In each iteration it looks at the lowest bit of the multiplier register. If that bit is one, it adds the current multiplicand register into the accumulator. In the same cycle the multiplicand register moves left by one place and the multiplier register moves right by one place.

The multiplicand register and the adder both have the full product width, which is the sum of the two operand widths. The multiplicand is therefore never truncated as it climbs. After the last multiplier bit has been consumed, the block drops busy and raises done for a single cycle. The accumulator keeps the full unsigned product on its output until the next accepted start. Intermediate partial sums can be seen on the product output while the operation runs.

Top module: `shift_add_mult`

## Requirements
- R1: While reset is asserted, and after it has been released, the block is idle: busy is 0, done is 0 and the product output is 0.
- R2: A start sampled at a clock edge while the block is idle captures both operands. In the next cycle, busy is 1 and the product output is 0.
- R3: After an accepted start, busy stays high for exactly B_W clock cycles, where B_W is the multiplier width.
- R4: In the cycle after the last iteration, done is 1 for exactly one cycle. Busy falls to 0 in that same cycle.
- R5: When done is 1, the product output equals the unsigned product of the captured operands at the full A_W+B_W width, with no overflow out of the adder.
- R6: After the k-th iteration, the product output equals the multiplicand times the low k bits of the multiplier (for example, 2 times 11 shows 2, 6, 6, 22).
- R7: A start sampled while busy is 1 is ignored. The operands presented with it do not affect the result, and the timing of busy and done is unchanged.
- R8: While the block is idle and no start is sampled, the product output holds its value.
- R9: An iteration whose tested multiplier bit is 0 leaves the product unchanged. The shifts still take place in that iteration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Request to begin a multiplication; only honoured when idle |
| mcand_i | input | A_W | Unsigned multiplicand operand |
| mplier_i | input | B_W | Unsigned multiplier operand |
| busy_o | output | 1 | High while iterations are running |
| done_o | output | 1 | One-cycle pulse when the product is complete |
| product_o | output | A_W+B_W | Accumulated product, valid when done and held while idle |

## Verification
The bench builds the block with A_W = 4 and B_W = 4. At this size every one of the 256 operand pairs can be run, and the partial sum after each of the four iterations can be compared with an arithmetic reference. Every carry pattern through the 8-bit adder is therefore exercised, including the largest product 15 × 15 and the zero-operand cases. Some runs inject a start with different operands in the middle of an operation, which shows that such a request changes neither the result nor the cycle count.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } smul_state_e;
endpackage

// File: rtl/smul_rst_sync.sv
module smul_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int B_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(B_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(B_W - 1);

  smul_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             last_step;

  assign last_step = (state_q == ST_RUN) && (cnt_q == LAST_CNT);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (last_step) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;

  // R4: done is a single-cycle pulse
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4: done only follows a running cycle
  p_done_after_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o));

  // R3: running ends only on the last count
  p_run_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(cnt_q) == LAST_CNT);

  // R7: start while running never ends or restarts a run early
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && cnt_q != LAST_CNT) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/smul_datapath.sv
module smul_datapath #(
  parameter int A_W = 8,
  parameter int B_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [A_W-1:0]     mcand_i,
  input  logic [B_W-1:0]     mplier_i,
  output logic [A_W+B_W-1:0] product_o
);
  localparam int P_W = A_W + B_W;

  logic [P_W-1:0] mcand_q, mcand_d;
  logic [B_W-1:0] mplier_q, mplier_d;
  logic [P_W-1:0] prod_q, prod_d;
  logic [P_W:0]   sum;
  logic           reg_en;

  assign reg_en = load_i | step_i;
  assign sum    = {1'b0, prod_q} + {1'b0, mcand_q};

  always_comb begin
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    prod_d   = prod_q;
    if (load_i) begin
      mcand_d  = {{B_W{1'b0}}, mcand_i};
      mplier_d = mplier_i;
      prod_d   = '0;
    end else if (step_i) begin
      mcand_d  = mcand_q << 1;
      mplier_d = mplier_q >> 1;
      if (mplier_q[0]) prod_d = sum[P_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      prod_q   <= '0;
    end else if (reg_en) begin
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      prod_q   <= prod_d;
    end
  end

  assign product_o = prod_q;

  // R9: a zero tested bit leaves the accumulator alone
  p_zero_bit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !mplier_q[0]) |=> $stable(product_o));

  // R5: the adder never carries out of the product width
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && mplier_q[0]) |-> !sum[P_W]);

  // R2: loading clears the product and latches the multiplier
  p_load_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (product_o == '0 && mplier_q == $past(mplier_i)));
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
  parameter int A_W = 8,
  parameter int B_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [A_W-1:0]     mcand_i,
  input  logic [B_W-1:0]     mplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [A_W+B_W-1:0] product_o
);
  logic rst_int_n;
  logic load;
  logic step;

  smul_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  smul_ctrl #(.B_W(B_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  smul_datapath #(.A_W(A_W), .B_W(B_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_i    (load),
    .step_i    (step),
    .mcand_i   (mcand_i),
    .mplier_i  (mplier_i),
    .product_o (product_o)
  );

  // R8: idle without start keeps the product
  p_product_hold_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy_o && !start_i) |=> $stable(product_o));

  // R1: idle outputs while internal reset is held
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_int_n |-> (!busy_o && !done_o && product_o == '0));
endmodule

// File: tb/tb_shift_add_mult.sv
module tb_shift_add_mult;
  localparam int AW = 4;
  localparam int BW = 4;
  localparam int PW = AW + BW;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] a_in;
  logic [BW-1:0] b_in;
  logic          busy;
  logic          done;
  logic [PW-1:0] prod;

  int total = 0;
  int bad   = 0;

  shift_add_mult #(.A_W(AW), .B_W(BW)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .mcand_i   (a_in),
    .mplier_i  (b_in),
    .busy_o    (busy),
    .done_o    (done),
    .product_o (prod)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_op(input int a, input int b, input bit inject);
    int held;
    @(negedge clk);
    start = 1'b1; a_in = AW'(a); b_in = BW'(b);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    check(prod == '0, "R2 product cleared", prod, 0);
    check(done == 1'b0, "R4 no done while loading", done, 0);
    for (int k = 1; k <= BW; k++) begin
      if (inject && k == 1) begin
        start = 1'b1; a_in = ~AW'(a); b_in = ~BW'(b);
      end
      @(negedge clk);
      start = 1'b0;
      check(prod == PW'(a * (b % (1 << k))), inject ? "R7 R6 partial sum" : "R6 R9 partial sum",
            prod, a * (b % (1 << k)));
      check(busy == (k < BW), "R3 busy length", busy, (k < BW));
      check(done == (k == BW), "R4 done timing", done, (k == BW));
    end
    check(prod == PW'(a * b), inject ? "R7 R5 final product" : "R5 final product", prod, a * b);
    held = int'(prod);
    a_in = ~a_in; b_in = ~b_in;
    @(negedge clk);
    check(done == 1'b0, "R4 done single cycle", done, 0);
    check(int'(prod) == held, "R8 product held", prod, held);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(prod == '0, "R1 product in reset", prod, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && prod == '0, "R1 idle after reset", {busy, done, prod}, 0);

    run_op(2, 11, 1'b0);
    for (int a = 0; a < (1 << AW); a++) begin
      for (int b = 0; b < (1 << BW); b++) begin
        run_op(a, b, ((a + b) % 5) == 0);
      end
    end

    repeat (5) begin
      @(negedge clk);
      a_in = a_in + 1'b1;
      check(prod == PW'(15 * 15) && busy == 1'b0, "R8 idle hold", prod, 225);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule